// File: doc/BRIEF.md
# UART Line Framer

This block turns bytes into asynchronous serial frames and back again. A transmitter takes bytes from a valid/ready stream and sends them on `txd`. A receiver recovers bytes from `rxd` and pushes them toward a receive FIFO. Both sides follow one frame format, set by an 8-bit frame control byte that holds the data length, the stop count, the parity type, a forced break and an internal loopback. A separate 16-bit idle limit forms the upper half of the control word. It sets how many idle bit periods the receiver waits, while the receive FIFO holds data, before it raises a timeout pulse.

All timing comes from `tick`, an oversampling strobe from an external baud generator. One bit period lasts `OVERSAMPLE` ticks. The receiver reports frame error, parity error, break, overflow and timeout as separate one-cycle pulses. The FIFOs, the interrupt logic and the modem flow control lie outside the block.

Top module: `uart_line_framer`

## Requirements
- R1: `frame_ctrl[1:0]` selects the data length: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Bits are sent and received LSB first, and unused upper bits of `rx_data` read as zero.
- R2: `frame_ctrl[2]` = 1 sends two stop bits, and 0 sends one. A frame holds `tx_ready` low for exactly (1 + length + parity + stops) x OVERSAMPLE ticks after it is accepted.
- R3: `frame_ctrl[5:3]` selects the parity: 000 none, 001 even, 011 odd, 101 mark (parity bit always 1), 111 space (parity bit always 0). Any code with bit 3 clear means no parity bit.
- R4: While `frame_ctrl[6]` is set, the transmit line is held low (a break), whatever the transmitter is doing.
- R5: While `frame_ctrl[7]` is set, the transmit serial stream feeds the receiver, `rxd` is ignored and `txd` stays high.
- R6: A start bit is a falling edge of the receive line that is still low half a bit later. A low pulse shorter than that produces no character and no event.
- R7: If the first stop bit is sampled low and the frame is not a break, `ev_frame_err` pulses once and the character is still delivered.
- R8: If the received parity bit does not match the selected parity, `ev_parity_err` pulses once and the character is still delivered.
- R9: If the data bits, the parity bit (when present) and the first stop bit are all low, `ev_break` pulses once. No character and no frame error is produced, and no new start is seen until the line has returned high.
- R10: `rx_valid` is asserted only in a cycle where `rx_ready` is high. If a character completes while `rx_ready` is low, `ev_overflow` pulses and the character is dropped.
- R11: `idle_limit` (bit periods, 0 = off) counts while `rx_pending` is high and the receiver is idle with the line high. `ev_timeout` pulses once when the count reaches the limit. Any received frame or a drop of `rx_pending` restarts the count.
- R12: `tx_ready` is high only when the transmitter is idle. The transmitter takes a byte on `tx_valid && tx_ready`, and the frame format is captured at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Oversampling strobe, OVERSAMPLE per bit |
| frame_ctrl | input | 8 | Length, stops, parity, break, loopback |
| idle_limit | input | 16 | Receive idle timeout in bit periods |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter idle, accepts a byte |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte pushed this cycle |
| rx_ready | input | 1 | Receive FIFO has room |
| rx_pending | input | 1 | Receive FIFO is non-empty |
| ev_frame_err | output | 1 | Stop bit sampled low |
| ev_parity_err | output | 1 | Parity mismatch |
| ev_break | output | 1 | Break received |
| ev_overflow | output | 1 | Character dropped, FIFO full |
| ev_timeout | output | 1 | Receive idle timeout |

## Verification
The bench builds the block with OVERSAMPLE = 4 and holds `tick` high. Each bit then lasts four clocks, so a full frame in every length, parity and stop combination fits in a few dozen cycles. The frame time can be measured in exact clock counts, and a small idle limit of five bit periods puts the timeout within reach. In this setup the half-bit start check works out to two clocks, so a one-clock glitch on `rxd` exercises the start-rejection path directly.

// File: rtl/uart_lf_pkg.sv
// Shared types and helpers for the UART line framer.
// Assumes data lengths of 5 to 8 bits encoded as 0..3.
package uart_lf_pkg;

    // Frame format as captured from the control byte.
    typedef struct packed {
        logic [1:0] len;       // 0..3 -> 5..8 data bits
        logic       two_stop;  // second stop bit
        logic [2:0] par;       // [0] enable, [1] odd/space, [2] sticky
    } frame_cfg_t;

    // Index of the last data bit for a length code.
    function automatic logic [2:0] last_bit(input logic [1:0] len);
        return 3'd4 + {1'b0, len};
    endfunction

    // Parity bit value for a data word; sel = par[2:1].
    function automatic logic parity_of(input logic [1:0] sel, input logic [1:0] len,
                                       input logic [7:0] d);
        logic [7:0] m;
        m = d & (8'hFF >> (2'd3 - len));
        return sel[1] ? ~sel[0] : ((^m) ^ sel[0]);
    endfunction

endpackage

// File: rtl/uart_lf_tx.sv
// Transmit framer: serialises one byte per frame using a snapshot of the
// frame format taken at acceptance. Assumes OVERSAMPLE >= 4.
module uart_lf_tx
    import uart_lf_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  frame_cfg_t cfg_i,
    input  logic [7:0] data_i,
    input  logic       valid_i,
    output logic       ready_o,
    output logic       ser_o
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] LAST_T = CW'(OVERSAMPLE - 1);

    typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_st_t;

    tx_st_t     st;
    logic [CW-1:0] cnt;
    logic [2:0] bidx;
    logic [7:0] sh;
    frame_cfg_t cfg_q;
    logic       stop2;
    logic       bit_end;

    assign bit_end = tick && (cnt == LAST_T);
    assign ready_o = (st == T_IDLE);

    // Frame sequencer: one state per field, OVERSAMPLE ticks per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= T_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            sh    <= '0;
            cfg_q <= '0;
            stop2 <= 1'b0;
        end else if (st == T_IDLE) begin
            if (valid_i) begin
                sh    <= data_i;
                cfg_q <= cfg_i;
                cnt   <= '0;
                bidx  <= '0;
                st    <= T_START;
            end
        end else begin
            if (tick) cnt <= bit_end ? '0 : cnt + 1'b1;
            if (bit_end) begin
                case (st)
                    T_START: st <= T_DATA;
                    T_DATA: begin
                        if (bidx == last_bit(cfg_q.len)) begin
                            st    <= cfg_q.par[0] ? T_PAR : T_STOP;
                            stop2 <= 1'b0;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end
                    T_PAR: begin
                        st    <= T_STOP;
                        stop2 <= 1'b0;
                    end
                    default: begin
                        if (cfg_q.two_stop && !stop2) stop2 <= 1'b1;
                        else                          st    <= T_IDLE;
                    end
                endcase
            end
        end
    end

    // Serial level for the current field.
    always_comb begin
        case (st)
            T_START: ser_o = 1'b0;
            T_DATA:  ser_o = sh[bidx];
            T_PAR:   ser_o = parity_of(cfg_q.par[2:1], cfg_q.len, sh);
            default: ser_o = 1'b1;
        endcase
    end

    // R12: an accepted byte starts a frame with a low start bit.
    p_accept_starts_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o) |=> (!ready_o && !ser_o));

endmodule

// File: rtl/uart_lf_rx.sv
// Receive framer: finds a start bit, samples each field mid-bit and
// classifies the frame. Assumes line_i is already synchronised.
module uart_lf_rx
    import uart_lf_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] len_i,
    input  logic [2:0] par_i,
    input  logic       line_i,
    input  logic       rx_ready_i,
    output logic [7:0] data_o,
    output logic       valid_o,
    output logic       frame_o,
    output logic       parity_o,
    output logic       break_o,
    output logic       overflow_o,
    output logic       idle_o
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] LAST_T = CW'(OVERSAMPLE - 1);
    localparam logic [CW-1:0] HALF_T = CW'(OVERSAMPLE / 2 - 1);

    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_DONE} rx_st_t;

    rx_st_t     st;
    logic [CW-1:0] cnt;
    logic [2:0] bidx;
    logic [7:0] dat;
    logic [1:0] len_q;
    logic [2:0] par_q;
    logic       prev, par_s, stop_s;
    logic       done, is_brk;

    // Receive sequencer: edge detect, mid-bit confirm, then one sample per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= R_IDLE; cnt <= '0; bidx <= '0; dat <= '0;
            len_q <= '0; par_q <= '0; prev <= 1'b1; par_s <= 1'b0; stop_s <= 1'b1;
        end else begin
            case (st)
                R_IDLE: if (tick) begin
                    prev <= line_i;
                    if (prev && !line_i) begin
                        st <= R_START; cnt <= '0; dat <= '0;
                        len_q <= len_i; par_q <= par_i;
                    end
                end
                R_START: if (tick) begin
                    if (cnt == HALF_T) begin
                        cnt <= '0; bidx <= '0;
                        st  <= line_i ? R_IDLE : R_DATA;
                    end else cnt <= cnt + 1'b1;
                end
                R_DONE: st <= R_IDLE;
                default: if (tick) begin
                    if (cnt == LAST_T) begin
                        cnt <= '0;
                        if (st == R_DATA) begin
                            dat[bidx] <= line_i;
                            if (bidx == last_bit(len_q)) st <= par_q[0] ? R_PAR : R_STOP;
                            else bidx <= bidx + 1'b1;
                        end else if (st == R_PAR) begin
                            par_s <= line_i; st <= R_STOP;
                        end else begin
                            stop_s <= line_i; prev <= line_i; st <= R_DONE;
                        end
                    end else cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // Frame classification, valid in the cycle after the stop sample.
    always_comb begin
        done       = (st == R_DONE);
        is_brk     = (dat == 8'h00) && !stop_s && (!par_q[0] || !par_s);
        valid_o    = done && !is_brk && rx_ready_i;
        overflow_o = done && !is_brk && !rx_ready_i;
        break_o    = done && is_brk;
        frame_o    = done && !is_brk && !stop_s;
        parity_o   = done && !is_brk && par_q[0] && (par_s != parity_of(par_q[2:1], len_q, dat));
        idle_o     = (st == R_IDLE) && line_i;
        data_o     = dat;
    end

    // R10: a push only happens into a FIFO with room.
    p_push_needs_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> rx_ready_i);
    // R10: a dropped character is never pushed.
    p_no_push_on_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> !valid_o);
    // R9: a break reports neither a character nor a frame error.
    p_break_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        break_o |-> !(valid_o || frame_o || overflow_o || parity_o));
    // R9: a break is followed by idle, never by a second event.
    p_break_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        break_o |=> !break_o);

endmodule

// File: rtl/uart_lf_timeout.sv
// Receive idle timer: counts bit periods while data waits in the FIFO and
// the receiver sits idle; fires once per idle stretch.
module uart_lf_timeout #(
    parameter int OVERSAMPLE = 16,
    parameter int LIMIT_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [LIMIT_W-1:0] limit_i,
    input  logic               pending_i,
    input  logic               idle_i,
    output logic               fire_o
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] LAST_T = CW'(OVERSAMPLE - 1);

    logic [CW-1:0]      sub;
    logic [LIMIT_W-1:0] bits;
    logic               fired;
    logic               run;

    assign run = pending_i && idle_i;

    // Bit-period counter with a single-shot fire pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub <= '0; bits <= '0; fired <= 1'b0; fire_o <= 1'b0;
        end else begin
            fire_o <= 1'b0;
            if (!run) begin
                sub <= '0; bits <= '0; fired <= 1'b0;
            end else if (tick) begin
                sub <= (sub == LAST_T) ? '0 : sub + 1'b1;
                if (sub == LAST_T && !fired) begin
                    bits <= bits + 1'b1;
                    if (limit_i != '0 && bits + 1'b1 == limit_i) begin
                        fired  <= 1'b1;
                        fire_o <= 1'b1;
                    end
                end
            end
        end
    end

    // R11: the timeout is a single-cycle pulse.
    p_timeout_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
    // R11: the timeout only follows a cycle with data pending.
    p_timeout_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(pending_i));

endmodule

// File: rtl/uart_line_framer.sv
// UART line framer top: decodes the control byte, routes break and
// loopback, synchronises rxd and joins transmitter, receiver and timer.
module uart_line_framer
    import uart_lf_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int LIMIT_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [7:0]         frame_ctrl,
    input  logic [LIMIT_W-1:0] idle_limit,
    input  logic [7:0]         tx_data,
    input  logic               tx_valid,
    output logic               tx_ready,
    output logic               txd,
    input  logic               rxd,
    output logic [7:0]         rx_data,
    output logic               rx_valid,
    input  logic               rx_ready,
    input  logic               rx_pending,
    output logic               ev_frame_err,
    output logic               ev_parity_err,
    output logic               ev_break,
    output logic               ev_overflow,
    output logic               ev_timeout
);
    frame_cfg_t cfg;
    logic       brk_en, loop_en;
    logic       ser, tx_line, rx_line, rx_idle;
    logic [1:0] rxd_sync;

    assign cfg     = '{len: frame_ctrl[1:0], two_stop: frame_ctrl[2], par: frame_ctrl[5:3]};
    assign brk_en  = frame_ctrl[6];
    assign loop_en = frame_ctrl[7];

    // Two-stage synchroniser for the asynchronous receive pin.
    always_ff @(posedge clk) begin
        if (!rst_n) rxd_sync <= 2'b11;
        else        rxd_sync <= {rxd_sync[0], rxd};
    end

    assign tx_line = brk_en ? 1'b0 : ser;
    assign txd     = loop_en ? 1'b1 : tx_line;
    assign rx_line = loop_en ? tx_line : rxd_sync[1];

    uart_lf_tx #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_i(cfg),
        .data_i(tx_data), .valid_i(tx_valid), .ready_o(tx_ready), .ser_o(ser)
    );

    uart_lf_rx #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .len_i(cfg.len), .par_i(cfg.par),
        .line_i(rx_line), .rx_ready_i(rx_ready), .data_o(rx_data), .valid_o(rx_valid),
        .frame_o(ev_frame_err), .parity_o(ev_parity_err), .break_o(ev_break),
        .overflow_o(ev_overflow), .idle_o(rx_idle)
    );

    uart_lf_timeout #(.OVERSAMPLE(OVERSAMPLE), .LIMIT_W(LIMIT_W)) u_to (
        .clk(clk), .rst_n(rst_n), .tick(tick), .limit_i(idle_limit),
        .pending_i(rx_pending), .idle_i(rx_idle), .fire_o(ev_timeout)
    );

    // R4: a forced break holds the external line low outside loopback.
    p_break_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_en && !loop_en && !tx_ready) |-> !txd);

endmodule

// File: tb/tb_uart_line_framer.sv
module tb_uart_line_framer;
    localparam int OS = 4;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
    logic [7:0] frame_ctrl = 8'h03;
    logic [15:0] idle_limit = 16'd0;
    logic [7:0] tx_data = 8'h00;
    logic tx_valid = 1'b0, rxd = 1'b1, rx_ready = 1'b1, rx_pending = 1'b0;
    logic tx_ready, txd, rx_valid;
    logic [7:0] rx_data;
    logic ev_frame_err, ev_parity_err, ev_break, ev_overflow, ev_timeout;

    int n_chk = 0, n_fail = 0, tx_cyc = 0;
    int n_fe = 0, n_pe = 0, n_brk = 0, n_ovf = 0, n_to = 0, n_val = 0;
    logic [7:0] last_rx = 8'h00;
    logic txd_low_in_loop = 1'b0;
    bit finished = 1'b0;

    uart_line_framer #(.OVERSAMPLE(OS)) dut (.*);

    always #10 clk = ~clk;

    // Event and push counters, sampled away from the active edge.
    always @(negedge clk) if (rst_n) begin
        if (ev_frame_err) n_fe++;
        if (ev_parity_err) n_pe++;
        if (ev_break) n_brk++;
        if (ev_overflow) n_ovf++;
        if (ev_timeout) n_to++;
        if (rx_valid) begin n_val++; last_rx = rx_data; end
        if (frame_ctrl[7] && !txd) txd_low_in_loop = 1'b1;
    end

    // Each row: frame_ctrl byte, data byte (all with loopback set).
    localparam logic [15:0] VEC [8] = '{16'h83A5, 16'h80FF, 16'h852A, 16'h8A55,
                                        16'h9BC3, 16'hAB00, 16'hBB81, 16'h9C13};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] msk(input logic [7:0] fc);
        return 8'hFF >> (2'd3 - fc[1:0]);
    endfunction

    function automatic logic epar(input logic [7:0] fc, input logic [7:0] d);
        logic [7:0] m;
        m = d & msk(fc);
        case (fc[5:3])
            3'b001: return ^m;
            3'b011: return ~^m;
            3'b101: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int nbits(input logic [7:0] fc);
        return 1 + 5 + int'(fc[1:0]) + int'(fc[3]) + (fc[2] ? 2 : 1);
    endfunction

    task automatic send_tx(input logic [7:0] d);
        @(negedge clk);
        tx_data = d; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0; tx_cyc = 0;
        while (!tx_ready) begin tx_cyc++; @(negedge clk); end
    endtask

    task automatic cap_tx(output logic [7:0] d, output logic p);
        d = 8'h00; p = 1'b0;
        @(negedge clk);
        while (txd) @(negedge clk);
        repeat (OS / 2) @(negedge clk);
        for (int b = 0; b < 5 + int'(frame_ctrl[1:0]); b++) begin
            repeat (OS) @(negedge clk);
            d[b] = txd;
        end
        repeat (OS) @(negedge clk);
        p = txd;
    endtask

    task automatic rx_frame(input logic [7:0] d, input bit flip, input logic stop_v);
        @(negedge clk);
        rxd = 1'b0; repeat (OS) @(negedge clk);
        for (int b = 0; b < 5 + int'(frame_ctrl[1:0]); b++) begin
            rxd = d[b]; repeat (OS) @(negedge clk);
        end
        if (frame_ctrl[3]) begin rxd = epar(frame_ctrl, d) ^ flip; repeat (OS) @(negedge clk); end
        rxd = stop_v; repeat (OS) @(negedge clk);
        rxd = 1'b1; repeat (3 * OS) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int b0, v0, f0, p0, o0, t0;
        logic [7:0] cd;
        logic cp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 / R4: reset state
        chk("R12 reset tx_ready", tx_ready, 1);
        chk("R4 reset txd idle", txd, 1);
        chk("R10 reset rx_valid", rx_valid, 0);

        // R1 R2 R3 R5 R12: loopback table
        for (int i = 0; i < 8; i++) begin
            frame_ctrl = VEC[i][15:8];
            v0 = n_val; f0 = n_fe; p0 = n_pe;
            send_tx(VEC[i][7:0]);
            repeat (3 * OS) @(negedge clk);
            chk("R2 frame length", tx_cyc, nbits(VEC[i][15:8]) * OS);
            chk("R5 loopback push", n_val - v0, 1);
            chk("R1 data", int'(last_rx), int'(VEC[i][7:0] & msk(VEC[i][15:8])));
            chk("R3 no parity/frame err", (n_pe - p0) + (n_fe - f0), 0);
        end
        chk("R5 txd high in loopback", txd_low_in_loop, 0);

        // R5: rxd ignored in loopback
        frame_ctrl = 8'h83; v0 = n_val; f0 = n_fe;
        rx_frame(8'h3C, 0, 1'b1);
        chk("R5 rxd ignored", (n_val - v0) + (n_fe - f0), 0);

        // R1 R3: external 8-bit even parity reception
        frame_ctrl = 8'h0B; v0 = n_val; p0 = n_pe;
        rx_frame(8'hB7, 0, 1'b1);
        chk("R1 ext push", n_val - v0, 1);
        chk("R1 ext data", int'(last_rx), 8'hB7);
        // R8: parity error
        rx_frame(8'h4E, 1, 1'b1);
        chk("R8 parity event", n_pe - p0, 1);
        chk("R8 still delivered", int'(last_rx), 8'h4E);

        // R7: frame error
        frame_ctrl = 8'h03; f0 = n_fe; b0 = n_brk; v0 = n_val;
        rx_frame(8'h5A, 0, 1'b0);
        chk("R7 frame event", n_fe - f0, 1);
        chk("R7 not break", n_brk - b0, 0);
        chk("R7 delivered", n_val - v0, 1);

        // R9: long break
        f0 = n_fe; b0 = n_brk; v0 = n_val;
        @(negedge clk); rxd = 1'b0;
        repeat (20 * OS) @(negedge clk);
        rxd = 1'b1;
        repeat (4 * OS) @(negedge clk);
        chk("R9 one break", n_brk - b0, 1);
        chk("R9 no char", n_val - v0, 0);
        chk("R9 no frame err", n_fe - f0, 0);

        // R6: short glitch
        v0 = n_val; f0 = n_fe; b0 = n_brk;
        @(negedge clk); rxd = 1'b0; @(negedge clk); rxd = 1'b1;
        repeat (15 * OS) @(negedge clk);
        chk("R6 glitch rejected", (n_val - v0) + (n_fe - f0) + (n_brk - b0), 0);

        // R10: overflow
        rx_ready = 1'b0; o0 = n_ovf; v0 = n_val;
        rx_frame(8'h99, 0, 1'b1);
        rx_ready = 1'b1;
        chk("R10 overflow event", n_ovf - o0, 1);
        chk("R10 dropped", n_val - v0, 0);

        // R1 R3: mark and space parity seen on txd
        frame_ctrl = 8'h2B;
        fork send_tx(8'h6D); cap_tx(cd, cp); join
        chk("R1 txd data", int'(cd), 8'h6D);
        chk("R3 mark parity", cp, 1);
        frame_ctrl = 8'h3B;
        fork send_tx(8'hFF); cap_tx(cd, cp); join
        chk("R3 space parity", cp, 0);

        // R4: forced break
        frame_ctrl = 8'h43; repeat (2) @(negedge clk);
        chk("R4 break low", txd, 0);
        frame_ctrl = 8'h03; repeat (2) @(negedge clk);
        chk("R4 break released", txd, 1);

        // R11: receive idle timeout
        idle_limit = 16'd5; rx_pending = 1'b1; t0 = n_to;
        repeat (60) @(negedge clk);
        chk("R11 single timeout", n_to - t0, 1);
        t0 = n_to;
        rx_frame(8'h21, 0, 1'b1);
        repeat (60) @(negedge clk);
        chk("R11 restart after char", n_to - t0, 1);
        rx_pending = 1'b0; t0 = n_to;
        repeat (60) @(negedge clk);
        chk("R11 no pending no timeout", n_to - t0, 0);
        idle_limit = 16'd0; rx_pending = 1'b1;
        repeat (60) @(negedge clk);
        chk("R11 zero limit off", n_to - t0, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule